// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block takes received Ethernet frames as a byte stream and stores them in memory. The memory holds a ring of fixed-size receive buffers, and each buffer is described by a two-word descriptor. The block walks the ring one descriptor at a time. A frame that does not fit in one buffer continues in the buffer of the next descriptor. Software owns a descriptor until it clears the descriptor's used bit. The block sets that bit only once the whole frame is safely in memory. It then marks the first fragment as the start of the frame and the last fragment as its end, and it writes the total length into the last fragment's status word.

The ring base comes from an input that is sampled while receive is disabled. The block talks to memory through a single-port master: one access per cycle, with read data returned on the cycle after the request. If the block finds a descriptor that software still holds, it writes nothing to that descriptor. It reports the condition as an event and discards the rest of the frame. A frame that ends with an error is also discarded, and the descriptors it touched are left unowned.

Top module: `rxring_writer`

## Requirements
- R1: A descriptor is 8 bytes at an 8-byte stride from the ring base. Its address word is at offset 0 and its status word at offset 4. In the address word, bit 0 is the used bit, bit 1 is the wrap bit and bits [AW-1:2] hold the word-aligned buffer address.
- R2: Frame bytes are packed little-endian into 32-bit words, starting at the buffer address. Each buffer holds 128 bytes, and a longer frame continues in the buffer of the next descriptor. In the final word of a frame, the lanes past the last byte are written as zero.
- R3: After a good frame is stored, the address word of every descriptor the frame used is rewritten with bit 0 set. All other bits of that word stay unchanged.
- R4: In the status word, bit 14 is set only for the first fragment of a frame and bit 15 only for the last. Bits [11:0] hold the total frame length in the last fragment and zero in every other fragment. All remaining bits are zero.
- R5: After a descriptor whose wrap bit is set, the next descriptor used is the one at the ring base. After any other descriptor, the next one is at the following 8-byte slot.
- R6: If the block fetches a descriptor whose used bit is already set, it writes neither of that descriptor's words. It pulses `evtBufNa` and `evtResErr` for one cycle and discards the rest of the frame. The next frame starts at the first descriptor of the discarded frame.
- R7: A frame whose last byte carries `inErr` is dropped. No used bit is set for it, no completion is signalled, and the next frame starts at the dropped frame's first descriptor.
- R8: When the used bits of a good frame have all been set, `evtRxDone` pulses for one cycle and `rxStatus` is set. `rxStatus` stays set until `clrStatus` is driven high; if both happen in the same cycle, setting wins.
- R9: While `rxEnable` is low, the block accepts and discards every input byte, performs no memory access, and holds its ring pointer at `ringBase`. The first frame after `rxEnable` rises therefore uses the descriptor at `ringBase`.
- R10: The status word of a frame's last fragment is written after the last data word of that frame.
- R11: While enabled and between frames, input bytes without `inSof` are accepted and discarded without any memory write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxEnable | input | 1 | Receive enable |
| ringBase | input | AW | Byte address of descriptor 0 |
| inValid | input | 1 | Input byte valid |
| inData | input | 8 | Input byte |
| inSof | input | 1 | Byte is the first of a frame |
| inEof | input | 1 | Byte is the last of a frame |
| inErr | input | 1 | Frame is bad; meaningful only with inEof |
| inReady | output | 1 | Byte is taken on this edge when inValid is high |
| memEn | output | 1 | Memory access request |
| memWe | output | 1 | Request is a write |
| memAddr | output | AW | Word-aligned byte address |
| memWdata | output | 32 | Write data |
| memRdata | input | 32 | Read data, one cycle after the read request |
| evtRxDone | output | 1 | One-cycle pulse when a frame is handed to software |
| evtBufNa | output | 1 | One-cycle pulse when a fetched descriptor is still owned by software |
| evtResErr | output | 1 | One-cycle pulse for a frame lost for lack of a buffer |
| rxStatus | output | 1 | Sticky flag for a completed frame |
| clrStatus | input | 1 | Clears rxStatus |

## Verification
The hardest case to reach is a descriptor that is still owned when it is fetched in the middle of a frame. In that case one fragment has already been written, and the frame must be abandoned and its start replayed. The bench creates this case by planting a used bit in its memory model on the descriptor after the current ring position, then sending a frame long enough to need a second buffer. It also sends an errored frame that spans two buffers. After each of these, it confirms that the next good frame lands on the abandoned frame's first descriptor.

// File: rtl/rxring_pkg.sv
package rxring_pkg;
  localparam int USED_BIT = 0;
  localparam int WRAP_BIT = 1;
  localparam int SOF_BIT  = 14;
  localparam int EOF_BIT  = 15;

  typedef enum logic [2:0] {
    MOP_NONE,
    MOP_RD_DESC,
    MOP_WR_STAT,
    MOP_RD_MARK,
    MOP_WR_MARK
  } memop_e;

  typedef struct packed {
    memop_e memOp;
    logic   loadBase;
    logic   startFrame;
    logic   takeDesc;
    logic   acceptByte;
    logic   lastFrag;
    logic   advance;
    logic   rewind;
    logic   markStart;
    logic   markStep;
    logic   markFinish;
  } ring_ctl_t;
endpackage

// File: rtl/rxring_datapath.sv
module rxring_datapath
  import rxring_pkg::*;
#(
  parameter int AW        = 16,
  parameter int BUF_BYTES = 128,
  parameter int LEN_W     = 12
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [AW-1:0] ringBase,
  input  logic [7:0]    inData,
  input  logic          inEof,
  input  ring_ctl_t     ctl,
  input  logic [31:0]   memRdata,
  output logic          memEn,
  output logic          memWe,
  output logic [AW-1:0] memAddr,
  output logic [31:0]   memWdata,
  output logic          descUsed,
  output logic          bufFull,
  output logic          markLast
);
  localparam int OFF_W = $clog2(BUF_BYTES);
  localparam int CNT_W = LEN_W - OFF_W + 1;
  localparam logic [AW-1:0] STRIDE = AW'(8);

  logic [AW-1:0]    baseReg, ptr, firstPtr, bufAddr, markPtr;
  logic             curWrap;
  logic [OFF_W-1:0] off;
  logic [LEN_W-1:0] frameLen;
  logic [CNT_W-1:0] fragCnt, markLeft;
  logic [3:0][7:0]  held;
  logic [1:0]       lane;
  logic             dataWrite;
  logic [31:0]      dataWord, statWord;
  logic [AW-1:0]    markNext;

  assign lane      = off[1:0];
  assign dataWrite = ctl.acceptByte && (lane == 2'd3 || inEof);
  assign descUsed  = memRdata[USED_BIT];
  assign bufFull   = (off == OFF_W'(BUF_BYTES - 1));
  assign markLast  = (markLeft == '0);
  assign markNext  = memRdata[WRAP_BIT] ? baseReg : markPtr + STRIDE;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseReg  <= '0;
      ptr      <= '0;
      firstPtr <= '0;
      bufAddr  <= '0;
      markPtr  <= '0;
      curWrap  <= 1'b0;
      off      <= '0;
      frameLen <= '0;
      fragCnt  <= '0;
      markLeft <= '0;
      held     <= '0;
    end else begin
      if (ctl.loadBase) begin
        baseReg <= {ringBase[AW-1:3], 3'b000};
        ptr     <= {ringBase[AW-1:3], 3'b000};
      end
      if (ctl.startFrame) begin
        firstPtr <= ptr;
        frameLen <= '0;
        fragCnt  <= '0;
      end
      if (ctl.takeDesc) begin
        bufAddr <= {memRdata[AW-1:2], 2'b00};
        curWrap <= memRdata[WRAP_BIT];
        off     <= '0;
      end
      if (ctl.acceptByte) begin
        off        <= off + 1'b1;
        frameLen   <= frameLen + 1'b1;
        held[lane] <= inData;
      end
      if (ctl.memOp == MOP_WR_STAT) fragCnt <= fragCnt + 1'b1;
      if (ctl.advance) ptr <= curWrap ? baseReg : ptr + STRIDE;
      if (ctl.rewind) ptr <= firstPtr;
      if (ctl.markStart) begin
        markPtr  <= firstPtr;
        markLeft <= fragCnt;
      end
      if (ctl.markStep) begin
        markPtr  <= markNext;
        markLeft <= markLeft - 1'b1;
      end
      if (ctl.markFinish) ptr <= markNext;
    end
  end

  always_comb begin
    dataWord = '0;
    for (int j = 0; j < 4; j++) begin
      if (j < int'(lane)) dataWord[j*8 +: 8] = held[j];
      else if (j == int'(lane)) dataWord[j*8 +: 8] = inData;
    end
  end

  always_comb begin
    statWord = '0;
    if (ctl.lastFrag) begin
      statWord[LEN_W-1:0] = frameLen;
      statWord[EOF_BIT]   = 1'b1;
    end
    if (fragCnt == '0) statWord[SOF_BIT] = 1'b1;
  end

  always_comb begin
    memEn    = 1'b0;
    memWe    = 1'b0;
    memAddr  = '0;
    memWdata = '0;
    if (dataWrite) begin
      memEn    = 1'b1;
      memWe    = 1'b1;
      memAddr  = bufAddr + AW'({off[OFF_W-1:2], 2'b00});
      memWdata = dataWord;
    end else begin
      unique case (ctl.memOp)
        MOP_RD_DESC: begin memEn = 1'b1; memAddr = ptr; end
        MOP_WR_STAT: begin
          memEn = 1'b1; memWe = 1'b1; memAddr = ptr + AW'(4); memWdata = statWord;
        end
        MOP_RD_MARK: begin memEn = 1'b1; memAddr = markPtr; end
        MOP_WR_MARK: begin
          memEn = 1'b1; memWe = 1'b1; memAddr = markPtr;
          memWdata = memRdata | 32'h1;
        end
        default: ;
      endcase
    end
  end

  AST_LAST_STATUS_AFTER_DATA: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.memOp == MOP_WR_STAT && ctl.lastFrag) |-> $past(memEn && memWe)); // R10

  AST_DATA_INSIDE_BUFFER: assert property (@(posedge clk) disable iff (!rstN)
    dataWrite |-> ((memAddr - bufAddr) < AW'(BUF_BYTES))); // R2
endmodule

// File: rtl/rxring_ctrl.sv
module rxring_ctrl
  import rxring_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      rxEnable,
  input  logic      inValid,
  input  logic      inSof,
  input  logic      inEof,
  input  logic      inErr,
  input  logic      descUsed,
  input  logic      bufFull,
  input  logic      markLast,
  input  logic      clrStatus,
  output ring_ctl_t ctl,
  output logic      inReady,
  output logic      evtRxDone,
  output logic      evtBufNa,
  output logic      evtResErr,
  output logic      rxStatus
);
  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_DATA, S_STAT, S_NEXT, S_DROP, S_MRD, S_MWR
  } state_e;

  state_e state, nxt;
  logic   lastFrag;

  always_comb begin
    ctl          = '0;
    ctl.lastFrag = lastFrag;
    inReady      = 1'b0;
    evtRxDone    = 1'b0;
    evtBufNa     = 1'b0;
    evtResErr    = 1'b0;
    nxt          = state;
    unique case (state)
      S_IDLE: begin
        if (!rxEnable) begin
          ctl.loadBase = 1'b1;
          inReady      = 1'b1;
        end else if (inValid && inSof) begin
          ctl.memOp      = MOP_RD_DESC;
          ctl.startFrame = 1'b1;
          nxt            = S_FETCH;
        end else begin
          inReady = 1'b1;
        end
      end
      S_FETCH: begin
        if (descUsed) begin
          evtBufNa   = 1'b1;
          evtResErr  = 1'b1;
          ctl.rewind = 1'b1;
          nxt        = S_DROP;
        end else begin
          ctl.takeDesc = 1'b1;
          nxt          = S_DATA;
        end
      end
      S_DATA: begin
        inReady = 1'b1;
        if (inValid) begin
          ctl.acceptByte = 1'b1;
          if (inEof && inErr) begin
            ctl.rewind = 1'b1;
            nxt        = S_IDLE;
          end else if (inEof || bufFull) begin
            nxt = S_STAT;
          end
        end
      end
      S_STAT: begin
        ctl.memOp = MOP_WR_STAT;
        if (lastFrag) begin
          ctl.markStart = 1'b1;
          nxt           = S_MRD;
        end else begin
          ctl.advance = 1'b1;
          nxt         = S_NEXT;
        end
      end
      S_NEXT: begin
        ctl.memOp = MOP_RD_DESC;
        nxt       = S_FETCH;
      end
      S_DROP: begin
        inReady = 1'b1;
        if (inValid && inEof) nxt = S_IDLE;
      end
      S_MRD: begin
        ctl.memOp = MOP_RD_MARK;
        nxt       = S_MWR;
      end
      S_MWR: begin
        ctl.memOp = MOP_WR_MARK;
        if (markLast) begin
          ctl.markFinish = 1'b1;
          evtRxDone      = 1'b1;
          nxt            = S_IDLE;
        end else begin
          ctl.markStep = 1'b1;
          nxt          = S_MRD;
        end
      end
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_IDLE;
      lastFrag <= 1'b0;
      rxStatus <= 1'b0;
    end else begin
      state <= nxt;
      if (state == S_DATA && inValid) lastFrag <= inEof;
      if (evtRxDone) rxStatus <= 1'b1;
      else if (clrStatus) rxStatus <= 1'b0;
    end
  end

  AST_NO_WRITE_AFTER_BUFNA: assert property (@(posedge clk) disable iff (!rstN)
    evtBufNa |=> (ctl.memOp == MOP_NONE && !ctl.acceptByte)); // R6

  AST_DONE_SETS_STATUS: assert property (@(posedge clk) disable iff (!rstN)
    evtRxDone |=> rxStatus); // R8

  AST_EVENTS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({evtRxDone, evtBufNa})); // R6

  AST_ERR_FRAME_NO_DONE: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_DATA && inValid && inEof && inErr) |=> (state == S_IDLE && !evtRxDone)); // R7
endmodule

// File: rtl/rxring_writer.sv
module rxring_writer
  import rxring_pkg::*;
#(
  parameter int AW        = 16,
  parameter int BUF_BYTES = 128,
  parameter int LEN_W     = 12
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          rxEnable,
  input  logic [AW-1:0] ringBase,
  input  logic          inValid,
  input  logic [7:0]    inData,
  input  logic          inSof,
  input  logic          inEof,
  input  logic          inErr,
  output logic          inReady,
  output logic          memEn,
  output logic          memWe,
  output logic [AW-1:0] memAddr,
  output logic [31:0]   memWdata,
  input  logic [31:0]   memRdata,
  output logic          evtRxDone,
  output logic          evtBufNa,
  output logic          evtResErr,
  output logic          rxStatus,
  input  logic          clrStatus
);
  ring_ctl_t ctl;
  logic      descUsed, bufFull, markLast;

  rxring_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .rxEnable(rxEnable), .inValid(inValid),
    .inSof(inSof), .inEof(inEof), .inErr(inErr), .descUsed(descUsed),
    .bufFull(bufFull), .markLast(markLast), .clrStatus(clrStatus),
    .ctl(ctl), .inReady(inReady), .evtRxDone(evtRxDone),
    .evtBufNa(evtBufNa), .evtResErr(evtResErr), .rxStatus(rxStatus)
  );

  rxring_datapath #(.AW(AW), .BUF_BYTES(BUF_BYTES), .LEN_W(LEN_W)) u_dp (
    .clk(clk), .rstN(rstN), .ringBase(ringBase), .inData(inData),
    .inEof(inEof), .ctl(ctl), .memRdata(memRdata), .memEn(memEn),
    .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .descUsed(descUsed), .bufFull(bufFull), .markLast(markLast)
  );
endmodule

// File: tb/rxring_writer_tb.sv
module rxring_writer_tb;
  localparam int AW = 16;
  localparam logic [AW-1:0] BASE = 16'h0100;
  localparam int NDESC = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #5 clk = ~clk;

  logic          rxEnable = 1'b0;
  logic [AW-1:0] ringBase = BASE;
  logic          inValid = 1'b0, inSof = 1'b0, inEof = 1'b0, inErr = 1'b0;
  logic [7:0]    inData = 8'h00;
  logic          inReady, memEn, memWe, evtRxDone, evtBufNa, evtResErr, rxStatus;
  logic          clrStatus = 1'b0;
  logic [AW-1:0] memAddr;
  logic [31:0]   memWdata;
  logic [31:0]   memRdata = 32'h0;

  rxring_writer u_dut (
    .clk(clk), .rstN(rstN), .rxEnable(rxEnable), .ringBase(ringBase),
    .inValid(inValid), .inData(inData), .inSof(inSof), .inEof(inEof),
    .inErr(inErr), .inReady(inReady), .memEn(memEn), .memWe(memWe),
    .memAddr(memAddr), .memWdata(memWdata), .memRdata(memRdata),
    .evtRxDone(evtRxDone), .evtBufNa(evtBufNa), .evtResErr(evtResErr),
    .rxStatus(rxStatus), .clrStatus(clrStatus)
  );

  logic [31:0] mem [0:1023];
  logic        swWe = 1'b0;
  logic [9:0]  swIdx = '0;
  logic [31:0] swData = '0;

  always @(posedge clk) begin
    if (swWe) mem[swIdx] <= swData;
    else if (memEn) begin
      if (memWe) mem[memAddr[11:2]] <= memWdata;
      else memRdata <= mem[memAddr[11:2]];
    end
  end

  int cyc = 0, wrCnt = 0, doneCnt = 0, naCnt = 0, resCnt = 0;
  int lastDataCyc = 0, eofStatCyc = 0;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) begin
    if (memEn && memWe) begin
      wrCnt <= wrCnt + 1;
      if (memAddr >= 16'h0200) lastDataCyc <= cyc;
      else if (memAddr[2] && memWdata[15]) eofStatCyc <= cyc;
    end
    if (evtRxDone) doneCnt <= doneCnt + 1;
    if (evtBufNa)  naCnt   <= naCnt + 1;
    if (evtResErr) resCnt  <= resCnt + 1;
  end

  int  checks = 0, errors = 0;
  bit  finished = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int dIdx(input int i);
    return (int'(BASE) >> 2) + 2 * i;
  endfunction
  function automatic logic [31:0] bufAddr(input int i);
    return 32'(32'h200 + i * 128);
  endfunction
  function automatic logic [31:0] addrWord(input int i);
    return bufAddr(i) | ((i == NDESC - 1) ? 32'h2 : 32'h0);
  endfunction
  function automatic logic [7:0] eb(input int f, input int b);
    return 8'(f * 37 + b * 7 + 1);
  endfunction

  task automatic sw_write(input int idx, input logic [31:0] d);
    @(negedge clk); swWe = 1'b1; swIdx = 10'(idx); swData = d;
    @(negedge clk); swWe = 1'b0;
  endtask

  task automatic release_desc(input int i);
    sw_write(dIdx(i), addrWord(i));
    sw_write(dIdx(i) + 1, 32'h0);
  endtask

  task automatic put_byte(input logic [7:0] d, input bit s, input bit e, input bit r);
    bit taken = 0;
    while (!taken) begin
      @(negedge clk);
      inValid = 1'b1; inData = d; inSof = s; inEof = e; inErr = r;
      #1;
      if (inReady) begin @(posedge clk); taken = 1; end
    end
  endtask

  task automatic send_frame(input int f, input int len, input bit err);
    for (int b = 0; b < len; b++) put_byte(eb(f, b), b == 0, b == len - 1, err && (b == len - 1));
    @(negedge clk); inValid = 1'b0; inSof = 1'b0; inEof = 1'b0; inErr = 1'b0;
    repeat (24) @(negedge clk);
  endtask

  task automatic check_frame(input int f, input int len, input int startIdx);
    int nfrag = (len + 127) / 128;
    for (int k = 0; k < nfrag; k++) begin
      int idx = (startIdx + k) % NDESC;
      int n = (k == nfrag - 1) ? len - k * 128 : 128;
      logic [31:0] expSw = 32'h0;
      int bad = 0;
      logic [31:0] badAct = 0, badExp = 0;
      chk(mem[dIdx(idx)] == (addrWord(idx) | 32'h1), "R1 R3 R5 address word", mem[dIdx(idx)], addrWord(idx) | 32'h1);
      if (k == 0) expSw[14] = 1'b1;
      if (k == nfrag - 1) begin expSw[15] = 1'b1; expSw[11:0] = 12'(len); end
      chk(mem[dIdx(idx) + 1] == expSw, "R4 status word", mem[dIdx(idx) + 1], expSw);
      for (int w = 0; w < (n + 3) / 4; w++) begin
        logic [31:0] ew = 32'h0;
        for (int j = 0; j < 4; j++)
          if (w * 4 + j < n) ew[j*8 +: 8] = eb(f, k * 128 + w * 4 + j);
        if (mem[(int'(bufAddr(idx)) >> 2) + w] !== ew && bad == 0) begin
          badAct = mem[(int'(bufAddr(idx)) >> 2) + w]; badExp = ew;
        end
        if (mem[(int'(bufAddr(idx)) >> 2) + w] !== ew) bad++;
      end
      chk(bad == 0, "R2 buffer data", badAct, badExp);
    end
    // R10: final status word after the final data word
    chk(eofStatCyc > lastDataCyc, "R10 status order", 32'(eofStatCyc), 32'(lastDataCyc));
    for (int k = 0; k < nfrag; k++) release_desc((startIdx + k) % NDESC);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int lens[17] = '{1, 2, 3, 4, 5, 8, 127, 128, 129, 200, 255, 256, 257, 300, 384, 385, 512};
    int expIdx = 0;
    int f = 0;
    int w0, d0, n0, r0;
    for (int i = 0; i < 1024; i++) mem[i] = 32'h0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk); #1;
    chk(inReady == 1'b1 && memEn == 1'b0, "R9 reset idle", {30'h0, inReady, memEn}, 32'h2);
    chk({evtRxDone, evtBufNa, evtResErr, rxStatus} == 4'h0, "R8 reset events", 32'({evtRxDone, evtBufNa, evtResErr, rxStatus}), 32'h0);
    for (int i = 0; i < NDESC; i++) release_desc(i);

    // R9: disabled receiver drops frames without memory traffic
    w0 = wrCnt; d0 = doneCnt;
    send_frame(99, 20, 0);
    chk(wrCnt == w0 && doneCnt == d0, "R9 disabled drop", 32'(wrCnt - w0), 32'h0);

    @(negedge clk); rxEnable = 1'b1;
    repeat (2) @(negedge clk);

    // R11: bytes outside a frame are discarded
    w0 = wrCnt;
    for (int b = 0; b < 5; b++) put_byte(8'hA5, 0, 0, 0);
    @(negedge clk); inValid = 1'b0;
    repeat (4) @(negedge clk);
    chk(wrCnt == w0, "R11 stray bytes", 32'(wrCnt - w0), 32'h0);

    foreach (lens[i]) begin
      d0 = doneCnt;
      send_frame(f, lens[i], 0);
      chk(doneCnt == d0 + 1, "R8 done pulse", 32'(doneCnt - d0), 32'h1);
      check_frame(f, lens[i], expIdx);
      expIdx = (expIdx + (lens[i] + 127) / 128) % NDESC;
      f++;
    end

    chk(rxStatus == 1'b1, "R8 status sticky", 32'(rxStatus), 32'h1);
    @(negedge clk); clrStatus = 1'b1;
    @(negedge clk); clrStatus = 1'b0; #1;
    chk(rxStatus == 1'b0, "R8 status clear", 32'(rxStatus), 32'h0);

    // R7: errored frame spanning two buffers
    d0 = doneCnt;
    send_frame(f, 200, 1);
    chk(doneCnt == d0, "R7 no done", 32'(doneCnt - d0), 32'h0);
    chk(mem[dIdx(expIdx)][0] == 1'b0 && mem[dIdx((expIdx + 1) % NDESC)][0] == 1'b0,
        "R7 no used bits", {mem[dIdx(expIdx)][0], mem[dIdx((expIdx + 1) % NDESC)][0]}, 32'h0);
    f++;
    send_frame(f, 10, 0);
    check_frame(f, 10, expIdx);
    expIdx = (expIdx + 1) % NDESC; f++;

    // R6: owned descriptor met in mid-frame
    sw_write(dIdx((expIdx + 1) % NDESC), addrWord((expIdx + 1) % NDESC) | 32'h1);
    d0 = doneCnt; n0 = naCnt; r0 = resCnt;
    send_frame(f, 150, 0);
    chk(naCnt == n0 + 1 && resCnt == r0 + 1, "R6 events", 32'(naCnt - n0), 32'h1);
    chk(doneCnt == d0, "R6 no done", 32'(doneCnt - d0), 32'h0);
    chk(mem[dIdx((expIdx + 1) % NDESC) + 1] == 32'h0 &&
        mem[dIdx((expIdx + 1) % NDESC)] == (addrWord((expIdx + 1) % NDESC) | 32'h1),
        "R6 owned untouched", mem[dIdx((expIdx + 1) % NDESC) + 1], 32'h0);
    chk(mem[dIdx(expIdx)][0] == 1'b0, "R6 first not used", 32'(mem[dIdx(expIdx)][0]), 32'h0);
    f++;
    release_desc((expIdx + 1) % NDESC);
    send_frame(f, 40, 0);
    check_frame(f, 40, expIdx);
    expIdx = (expIdx + 1) % NDESC; f++;

    // R6: owned descriptor at frame start
    sw_write(dIdx(expIdx), addrWord(expIdx) | 32'h1);
    n0 = naCnt; w0 = wrCnt;
    send_frame(f, 10, 0);
    chk(naCnt == n0 + 1 && wrCnt == w0, "R6 first owned", 32'(wrCnt - w0), 32'h0);
    f++;
    release_desc(expIdx);
    send_frame(f, 10, 0);
    check_frame(f, 10, expIdx);
    expIdx = (expIdx + 1) % NDESC; f++;

    // R9: re-enable restarts at the ring base
    @(negedge clk); rxEnable = 1'b0;
    repeat (3) @(negedge clk);
    rxEnable = 1'b1;
    repeat (2) @(negedge clk);
    send_frame(f, 9, 0);
    chk(mem[dIdx(0)][0] == 1'b1, "R9 restart at base", 32'(mem[dIdx(0)][0]), 32'h1);
    check_frame(f, 9, 0);

    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule